// File: doc/BRIEF.md
# Mains Zero-Cross Locked Bit Clock

This block derives a bit-rate timing grid from a fast crystal clock and keeps that grid locked to the rising zero crossings of the mains. A programmable divider produces a one-cycle enable, `chip_clk_en`, at eight times the bit rate. A period counter splits each mains period into a fixed number of bit slots. It marks every slot with `bit_stb` and the start of every period with `frame_stb`. The default settings give 2400 baud from 48 MHz with 48 bits per 20 ms.

The comparator input is synchronised and debounced. Each debounced rising edge is then compared with the internal period counter. A crossing that lands in the first half of the period counts as late, and the divider grows by one. A crossing in the second half counts as early, and the divider shrinks by one. The divider is held inside a fixed window around its nominal value. This way the loop pulls the grid towards the mains gradually and does not retrigger on each crossing, so noise on a single crossing does not disturb the timing.

A lock flag reports when crossings consistently fall close to the period start. If crossings stop arriving, the loop runs freely on its last divider value and drops the lock.

Top module: `mains_bit_pll`

## Requirements
- R1: A synchronous active-high reset clears the lock flag and all counters and loads DIV_NOM into the divider. After reset, `chip_clk_en` pulses once every DIV_NOM clock cycles.
- R2: `chip_clk_en` is a one-cycle pulse. Consecutive pulses are spaced by the current divider value, in clock cycles.
- R3: `bit_stb` marks every OVS-th `chip_clk_en` pulse. `frame_stb` marks every PER = OVS*BITS-th pulse. Each `frame_stb` coincides with a `bit_stb`, and each period holds exactly BITS bit strobes.
- R4: `zc_in` passes through two synchroniser flops and a filter. The filter accepts a new level only after it has held for DEB_LEN cycles, so a pulse shorter than that changes nothing.
- R5: Only a rising edge of the filtered input acts as phase reference. A falling edge leaves the divider unchanged.
- R6: Let phase p (0..PER-1) be the period position at a rising edge. If p is in 1..PER/2-1, the divider grows by one. If p is in PER/2..PER-1, it shrinks by one. If p is 0, it stays unchanged.
- R7: The divider never leaves the range DIV_NOM-DIV_RANGE to DIV_NOM+DIV_RANGE.
- R8: `locked` rises on the LOCK_N-th consecutive rising edge whose distance from the period start is at most LOCK_TOL ticks.
- R9: `locked` falls on the LOCK_N-th consecutive rising edge whose distance from the period start exceeds UNLOCK_TOL ticks.
- R10: If no rising edge arrives for PER+PER/2 ticks, `locked` clears and the divider keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Raw mains zero-cross comparator level |
| chip_clk_en | output | 1 | Enable pulse at OVS times the bit rate |
| bit_stb | output | 1 | Start of a bit slot |
| frame_stb | output | 1 | Period wrap, the expected zero cross |
| locked | output | 1 | Loop lock status |

## Verification
A raised `zc_in` takes effect on the sixth clock edge after it is driven. That delay is made of two synchroniser flops, DEB_LEN filter cycles and one edge register. With the bench divider this lands within one tick of the intended phase. Stimulus is therefore placed at least three ticks away from the late/early boundary and the period start. A divider change is never judged on the interval in which it happens. The bench waits for the next `frame_stb` and then measures a whole tick interval. The lock flag is updated on the same edge that consumes the crossing, so it is sampled two ticks after the input is raised. The timeout boundary is probed at 40 ticks, where the flag must still be set, and at 56 ticks, where it must be clear.

// File: rtl/mains_bit_pll.sv
module mains_bit_pll #(
  parameter int DIV_NOM    = 2500,
  parameter int DIV_RANGE  = 25,
  parameter int OVS        = 8,
  parameter int BITS       = 48,
  parameter int DEB_LEN    = 16,
  parameter int LOCK_TOL   = 2,
  parameter int UNLOCK_TOL = 8,
  parameter int LOCK_N     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  output logic chip_clk_en,
  output logic bit_stb,
  output logic frame_stb,
  output logic locked
);
  localparam int PER = OVS * BITS;
  localparam int PW  = $clog2(PER);
  localparam int DW  = $clog2(DIV_NOM + DIV_RANGE + 1);
  localparam int TO  = PER + PER / 2;
  localparam int SW  = $clog2(TO + 1);
  localparam int BW  = $clog2(DEB_LEN + 1);
  localparam int OW  = $clog2(OVS);
  localparam int LW  = $clog2(LOCK_N + 1);
  localparam logic [DW-1:0] DIV_MAX = DW'(DIV_NOM + DIV_RANGE);
  localparam logic [DW-1:0] DIV_MIN = DW'(DIV_NOM - DIV_RANGE);

  logic s1, s2, zf, zf_d;
  logic [BW-1:0] dcnt;
  logic zc_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; zf <= 1'b0; zf_d <= 1'b0; dcnt <= '0;
    end else begin
      s1   <= zc_in;
      s2   <= s1;
      zf_d <= zf;
      if (s2 == zf) dcnt <= '0;
      else if (dcnt == BW'(DEB_LEN - 1)) begin
        zf   <= s2;
        dcnt <= '0;
      end else dcnt <= dcnt + 1'b1;
    end
  end

  assign zc_evt = zf & ~zf_d;

  logic [DW-1:0] div_val, div_cnt;
  logic [PW-1:0] phase;
  logic [OW-1:0] slot;

  assign chip_clk_en = div_cnt >= div_val - 1'b1;
  assign bit_stb     = chip_clk_en && slot == OW'(OVS - 1);
  assign frame_stb   = chip_clk_en && phase == PW'(PER - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0; phase <= '0; slot <= '0;
    end else begin
      div_cnt <= chip_clk_en ? '0 : div_cnt + 1'b1;
      if (chip_clk_en) begin
        slot  <= (slot == OW'(OVS - 1)) ? '0 : slot + 1'b1;
        phase <= frame_stb ? '0 : phase + 1'b1;
      end
    end
  end

  logic late, early;
  logic [PW:0] mag;
  assign late  = phase != '0 && phase < PW'(PER / 2);
  assign early = phase >= PW'(PER / 2);
  assign mag   = early ? (PW+1)'(PER) - {1'b0, phase} : {1'b0, phase};

  always_ff @(posedge clk) begin
    if (rst) div_val <= DW'(DIV_NOM);
    else if (zc_evt) begin
      if (late && div_val < DIV_MAX) div_val <= div_val + 1'b1;
      else if (early && div_val > DIV_MIN) div_val <= div_val - 1'b1;
    end
  end

  logic [LW-1:0] in_cnt, out_cnt;
  logic [SW-1:0] since;
  logic free_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt <= '0; out_cnt <= '0; since <= '0; free_run <= 1'b0; locked <= 1'b0;
    end else if (zc_evt) begin
      since    <= '0;
      free_run <= 1'b0;
      if (mag <= (PW+1)'(LOCK_TOL)) begin
        out_cnt <= '0;
        if (in_cnt != LW'(LOCK_N)) in_cnt <= in_cnt + 1'b1;
        if (in_cnt >= LW'(LOCK_N - 1)) locked <= 1'b1;
      end else if (mag > (PW+1)'(UNLOCK_TOL)) begin
        in_cnt <= '0;
        if (out_cnt != LW'(LOCK_N)) out_cnt <= out_cnt + 1'b1;
        if (out_cnt >= LW'(LOCK_N - 1)) locked <= 1'b0;
      end else begin
        in_cnt  <= '0;
        out_cnt <= '0;
      end
    end else if (chip_clk_en && !free_run) begin
      if (since == SW'(TO - 1)) begin
        free_run <= 1'b1;
        locked   <= 1'b0;
        in_cnt   <= '0;
        out_cnt  <= '0;
      end else since <= since + 1'b1;
    end
  end

  p_frame_on_bit_r3: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> bit_stb && chip_clk_en);
  p_div_moves_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_val) |-> $past(zc_evt));
  p_div_window_r7: assert property (@(posedge clk) disable iff (rst)
    div_val >= DIV_MIN && div_val <= DIV_MAX);
  p_lock_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(zc_evt));
  p_freerun_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    free_run |-> !locked);
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    chip_clk_en |=> !chip_clk_en);
endmodule

// File: tb/test_mains_bit_pll.sv
module test_mains_bit_pll;
  localparam int DIV_NOM = 6, DIV_RANGE = 2, OVS = 8, BITS = 4, DEB_LEN = 3;
  localparam int PER = OVS * BITS;

  logic clk = 1'b0, rst = 1'b1, zc_in = 1'b0;
  logic chip_clk_en, bit_stb, frame_stb, locked;
  int checks = 0, errors = 0, cur_div = DIV_NOM;

  always #2 clk = ~clk;

  mains_bit_pll #(.DIV_NOM(DIV_NOM), .DIV_RANGE(DIV_RANGE), .OVS(OVS), .BITS(BITS),
                  .DEB_LEN(DEB_LEN), .LOCK_TOL(2), .UNLOCK_TOL(8), .LOCK_N(4))
    i_mains_bit_pll (.clk(clk), .rst(rst), .zc_in(zc_in), .chip_clk_en(chip_clk_en),
                     .bit_stb(bit_stb), .frame_stb(frame_stb), .locked(locked));

  function automatic int next_div(int prev, bit late_edge);
    int n = late_edge ? prev + 1 : prev - 1;
    if (n > DIV_NOM + DIV_RANGE) n = DIV_NOM + DIV_RANGE;
    if (n < DIV_NOM - DIV_RANGE) n = DIV_NOM - DIV_RANGE;
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) do @(negedge clk); while (!chip_clk_en);
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame_stb);
  endtask

  task automatic measure(output int n);
    wait_ticks(1);
    n = 0;
    do begin @(negedge clk); n++; end while (!chip_clk_en);
  endtask

  task automatic edge_at(int k, int hold);
    wait_frame();
    wait_ticks(k);
    zc_in = 1'b1;
    wait_ticks(hold);
    zc_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int iv, ticks, bits;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 tick in reset", int'(chip_clk_en | frame_stb), 0);
    rst = 1'b0;
    measure(iv);
    chk("R1 nominal interval", iv, DIV_NOM);
    measure(iv);
    chk("R2 interval", iv, DIV_NOM);

    wait_frame();
    ticks = 0; bits = 0;
    do begin
      @(negedge clk);
      if (chip_clk_en) ticks++;
      if (bit_stb) bits++;
    end while (!frame_stb);
    chk("R3 ticks per frame", ticks, PER);
    chk("R3 bits per frame", bits, BITS);

    for (int r = 0; r < 3; r++) begin
      edge_at(4, 2);
      cur_div = next_div(cur_div, 1'b1);
      wait_frame(); measure(iv);
      chk("R6 late edge R7 clamp", iv, cur_div);
    end
    edge_at(PER - 5, 2);
    cur_div = next_div(cur_div, 1'b0);
    wait_frame(); measure(iv);
    chk("R6 early edge", iv, cur_div);

    wait_frame(); wait_ticks(4);
    zc_in = 1'b1; @(negedge clk); @(negedge clk); zc_in = 1'b0;
    wait_frame(); measure(iv);
    chk("R4 short pulse ignored", iv, cur_div);

    wait_frame(); wait_ticks(4);
    zc_in = 1'b1; wait_ticks(20); zc_in = 1'b0;
    cur_div = next_div(cur_div, 1'b1);
    wait_frame(); wait_frame(); measure(iv);
    chk("R5 falling edge ignored", iv, cur_div);

    for (int e = 1; e <= 4; e++) begin
      edge_at(0, 2);
      if (e == 3) chk("R8 not locked after 3", int'(locked), 0);
      if (e == 4) chk("R8 locked after 4", int'(locked), 1);
    end
    for (int e = 1; e <= 4; e++) begin
      edge_at(12, 2);
      if (e == 3) chk("R9 still locked after 3", int'(locked), 1);
      if (e == 4) chk("R9 unlocked after 4", int'(locked), 0);
    end

    for (int e = 1; e <= 4; e++) edge_at(0, 2);
    chk("R8 relock", int'(locked), 1);
    measure(iv);
    cur_div = iv;
    wait_ticks(38);
    chk("R10 locked before timeout", int'(locked), 1);
    wait_ticks(16);
    chk("R10 unlocked on timeout", int'(locked), 0);
    measure(iv);
    chk("R10 divider held", iv, cur_div);

    for (int r = 0; r < 16; r++) begin
      bit lt = 1'($urandom_range(0, 1));
      int k = lt ? int'($urandom_range(3, 12)) : int'($urandom_range(20, 27));
      edge_at(k, 2);
      cur_div = next_div(cur_div, lt);
      wait_frame(); measure(iv);
      chk(lt ? "R6 random late" : "R6 random early", iv, cur_div);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule